// File: doc/BRIEF.md
# Accumulator ALU with Flag-Driven Condition Evaluation

This block holds the 32-bit accumulator and the 16-bit flag register of a small 16-bit signal-processing core. It carries out one accumulator operation per clock when the core presents a valid operation. Loads and the arithmetic group (add, subtract, compare) work on the upper half of the accumulator. The logic group (AND, OR, XOR) works on the whole 32-bit accumulator, with the operand placed in the upper half.

A condition evaluator reads a 4-bit condition field and a polarity bit and reports taken or not taken from the current flags. The core's branch logic uses this result. So does the conditional modifier operation, which shifts, negates or takes the absolute value of the accumulator only when the condition is true. An unsupported condition field gives not taken and raises a one-cycle illegal flag.

The operand either comes from the operand port or, when the source index is 0, from the constant register, which always supplies all ones.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted operation, `acc` and `status` are zero.
- R2: Status layout: L at bit 12, Z at bit 13, V at bit 14 and N at bit 15. Bits 11..0 always read 0.
- R3: `op_code` 1 (load-high) writes the operand into `acc[31:16]` and keeps `acc[15:0]`. Z is then set if the whole 32-bit accumulator is zero. Otherwise N takes `acc[31]`. L and V are unchanged.
- R4: `op_code` 4 (add) and 2 (subtract) form a 17-bit intermediate from `acc[31:16]` plus or minus the operand. Bits 15..0 of the intermediate go to `acc[31:16]` and `acc[15:0]` is kept. Z is set when the 17-bit intermediate is zero, N takes its bit 15, and L and V are cleared.
- R5: `op_code` 3 (compare) updates the flags exactly as subtract does and leaves `acc` unchanged.
- R6: `op_code` 5 (AND), 6 (OR) and 7 (XOR) combine `{operand, 16'h0000}` with the full accumulator. AND therefore clears `acc[15:0]`. Z and N follow the 32-bit result as in R3.
- R7: `op_code` 8 (modifier) acts only when the condition is taken. `mod_sel` 2 is a logical shift right by one, 3 a shift left by one, 6 a two's-complement negate, and 7 the absolute value of the 32-bit accumulator. Z and N then follow the 32-bit result. Other `mod_sel` values, or a condition that is not taken, leave `acc` and `status` unchanged.
- R8: `cond_taken` is combinational from the current flags. `cond_field` 0 is always taken. `cond_field` 5 is taken when Z equals `cond_pol`, and `cond_field` 7 is taken when N equals `cond_pol`.
- R9: Any other `cond_field` value gives `cond_taken` = 0. `cond_illegal` is high in each cycle where such a field is presented with `cond_req` high or with a valid modifier operation.
- R10: `src_idx` 0 selects the constant register, which reads as 0xFFFF whatever the operand port carries. Any other index uses `operand`.
- R11: With `op_valid` low, or with an `op_code` value of 0 or from 9 to 15, `acc` and `status` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (see R3 to R7, R11) |
| src_idx | input | 4 | Operand source index; 0 is the constant register |
| operand | input | 16 | Operand value for non-zero source index |
| mod_sel | input | 3 | Modifier sub-operation for op_code 8 |
| cond_field | input | 4 | Condition code |
| cond_pol | input | 1 | Condition polarity bit |
| cond_req | input | 1 | Condition evaluation request from branch logic |
| acc | output | 32 | Accumulator |
| status | output | 16 | Flag register |
| cond_taken | output | 1 | Condition result |
| cond_illegal | output | 1 | Unsupported condition field presented |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before use. They also assume that every input is stable and known around each rising edge. The stimulus meets both conditions by driving all inputs on the falling edge only, after a multi-cycle reset.

The assertions also rely on V and L never being set by any path into the block, since no operation sets them. The random stimulus covers every op_code and condition field. It seeds operands equal to the current upper half so that the zero-flag paths are exercised. Directed sequences force negative and zero accumulators before the condition and modifier checks.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [3:0]    src_idx,
  input  logic [DW-1:0] operand,
  input  logic [2:0]    mod_sel,
  input  logic [3:0]    cond_field,
  input  logic          cond_pol,
  input  logic          cond_req,
  output logic [2*DW-1:0] acc,
  output logic [DW-1:0] status,
  output logic          cond_taken,
  output logic          cond_illegal
);
  localparam int AW    = 2 * DW;
  localparam int F_L   = DW - 4;
  localparam int F_Z   = DW - 3;
  localparam int F_V   = DW - 2;
  localparam int F_N   = DW - 1;

  localparam logic [3:0] OP_LDH = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_CMP = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_MOD = 4'd8;

  localparam logic [3:0] CF_ALW = 4'd0;
  localparam logic [3:0] CF_Z   = 4'd5;
  localparam logic [3:0] CF_N   = 4'd7;

  logic [AW-1:0] acc_q, acc_d;
  logic [DW-1:0] st_q, st_d;
  logic [DW-1:0] opnd, hi;
  logic [DW:0]   sum, dif, arith;
  logic [AW-1:0] mod_res;
  logic          mod_ok, cf_legal, cf_match;

  assign hi   = acc_q[AW-1:DW];
  assign opnd = (src_idx == 4'd0) ? {DW{1'b1}} : operand;
  assign sum  = {1'b0, hi} + {1'b0, opnd};
  assign dif  = {1'b0, hi} - {1'b0, opnd};
  assign arith = (op_code == OP_ADD) ? sum : dif;

  assign cf_legal = (cond_field == CF_ALW) || (cond_field == CF_Z) || (cond_field == CF_N);
  always_comb begin
    unique case (cond_field)
      CF_Z:    cf_match = (st_q[F_Z] == cond_pol);
      CF_N:    cf_match = (st_q[F_N] == cond_pol);
      default: cf_match = 1'b1;
    endcase
  end
  assign cond_taken   = cf_legal && cf_match;
  assign cond_illegal = !cf_legal && (cond_req || (op_valid && op_code == OP_MOD));

  always_comb begin
    mod_ok  = 1'b1;
    mod_res = acc_q;
    unique case (mod_sel)
      3'd2:    mod_res = acc_q >> 1;
      3'd3:    mod_res = acc_q << 1;
      3'd6:    mod_res = -acc_q;
      3'd7:    mod_res = acc_q[AW-1] ? -acc_q : acc_q;
      default: mod_ok  = 1'b0;
    endcase
  end

  function automatic logic [DW-1:0] zn_wide(input logic [DW-1:0] st, input logic [AW-1:0] v);
    logic [DW-1:0] r;
    r = st;
    r[F_Z] = (v == '0);
    r[F_N] = (v != '0) && v[AW-1];
    return r;
  endfunction

  always_comb begin
    acc_d = acc_q;
    st_d  = st_q;
    if (op_valid) begin
      unique case (op_code)
        OP_LDH: begin
          acc_d = {opnd, acc_q[DW-1:0]};
          st_d  = zn_wide(st_q, acc_d);
        end
        OP_ADD, OP_SUB, OP_CMP: begin
          if (op_code != OP_CMP) acc_d = {arith[DW-1:0], acc_q[DW-1:0]};
          st_d[F_L] = 1'b0;
          st_d[F_V] = 1'b0;
          st_d[F_Z] = (arith == '0);
          st_d[F_N] = arith[DW-1];
        end
        OP_AND, OP_OR, OP_XOR: begin
          if (op_code == OP_AND)     acc_d = acc_q & {opnd, {DW{1'b0}}};
          else if (op_code == OP_OR) acc_d = acc_q | {opnd, {DW{1'b0}}};
          else                       acc_d = acc_q ^ {opnd, {DW{1'b0}}};
          st_d = zn_wide(st_q, acc_d);
        end
        OP_MOD: begin
          if (cond_taken && mod_ok) begin
            acc_d = mod_res;
            st_d  = zn_wide(st_q, mod_res);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      acc_q <= acc_d;
      st_q  <= st_d;
    end
  end

  assign acc    = acc_q;
  assign status = st_q;
endmodule

module acc_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [31:0] acc,
  input logic [15:0] status,
  input logic        cond_taken,
  input logic        cond_illegal
);
  AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd3 |=> $stable(acc)); // R5
  AST_ARITH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 4'd2 || op_code == 4'd4) |=> $stable(acc[15:0])); // R4
  AST_ARITH_CLEARS_LV: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code >= 4'd2 && op_code <= 4'd4) |=> !status[12] && !status[14]); // R4
  AST_AND_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd5 |=> acc[15:0] == 16'h0); // R6
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[11:0] == 12'h0); // R2
  AST_Z_EXCLUDES_N: assert property (@(posedge clk) disable iff (!rst_n)
    status[13] |-> !status[15]); // R3
  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cond_illegal |-> !cond_taken); // R9
  AST_MOD_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd8 && !cond_taken |=> $stable(acc) && $stable(status)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc) && $stable(status)); // R11
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .acc(acc), .status(status), .cond_taken(cond_taken), .cond_illegal(cond_illegal)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [3:0]  src_idx = 4'd1;
  logic [15:0] operand = '0;
  logic [2:0]  mod_sel = '0;
  logic [3:0]  cond_field = '0;
  logic        cond_pol = 1'b0;
  logic        cond_req = 1'b0;
  logic [31:0] acc;
  logic [15:0] status;
  logic        cond_taken, cond_illegal;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_acc = '0;
  logic [15:0] m_st  = '0;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_idx(src_idx), .operand(operand), .mod_sel(mod_sel),
    .cond_field(cond_field), .cond_pol(cond_pol), .cond_req(cond_req),
    .acc(acc), .status(status), .cond_taken(cond_taken), .cond_illegal(cond_illegal)
  );

  function automatic string tag_of(input logic v, input logic [3:0] op);
    if (!v || op == 4'd0 || op > 4'd8) return "R11";
    case (op)
      4'd1: return "R3";
      4'd2, 4'd4: return "R4";
      4'd3: return "R5";
      4'd5, 4'd6, 4'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic exp_taken(input logic [15:0] st, input logic [3:0] cf, input logic pol);
    case (cf)
      4'd0: return 1'b1;
      4'd5: return st[13] == pol;
      4'd7: return st[15] == pol;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] zn(input logic [15:0] st, input logic [31:0] a);
    logic [15:0] r;
    r = st;
    r[13] = (a == 32'h0);
    r[15] = (a != 32'h0) && a[31];
    return r;
  endfunction

  task automatic model_step();
    logic [15:0] x, hi;
    logic [16:0] t;
    logic tk;
    x  = (src_idx == 4'd0) ? 16'hFFFF : operand;
    hi = m_acc[31:16];
    tk = exp_taken(m_st, cond_field, cond_pol);
    if (!op_valid) return;
    case (op_code)
      4'd1: begin m_acc = {x, m_acc[15:0]}; m_st = zn(m_st, m_acc); end
      4'd2, 4'd3, 4'd4: begin
        t = (op_code == 4'd4) ? ({1'b0, hi} + {1'b0, x}) : ({1'b0, hi} - {1'b0, x});
        if (op_code != 4'd3) m_acc = {t[15:0], m_acc[15:0]};
        m_st[12] = 1'b0; m_st[14] = 1'b0;
        m_st[13] = (t == 17'h0); m_st[15] = t[15];
      end
      4'd5: begin m_acc = m_acc & {x, 16'h0}; m_st = zn(m_st, m_acc); end
      4'd6: begin m_acc = m_acc | {x, 16'h0}; m_st = zn(m_st, m_acc); end
      4'd7: begin m_acc = m_acc ^ {x, 16'h0}; m_st = zn(m_st, m_acc); end
      4'd8: if (tk) begin
        case (mod_sel)
          3'd2: begin m_acc = m_acc >> 1; m_st = zn(m_st, m_acc); end
          3'd3: begin m_acc = m_acc << 1; m_st = zn(m_st, m_acc); end
          3'd6: begin m_acc = -m_acc; m_st = zn(m_st, m_acc); end
          3'd7: begin if (m_acc[31]) m_acc = -m_acc; m_st = zn(m_st, m_acc); end
          default: ;
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [3:0] si,
                      input logic [15:0] x, input logic [2:0] ms,
                      input logic [3:0] cf, input logic pol, input logic cr);
    logic et, ei;
    string tg;
    op_valid = v; op_code = op; src_idx = si; operand = x;
    mod_sel = ms; cond_field = cf; cond_pol = pol; cond_req = cr;
    #1;
    et = exp_taken(m_st, cf, pol);
    ei = !(cf == 4'd0 || cf == 4'd5 || cf == 4'd7) && (cr || (v && op == 4'd8));
    chk(cond_taken == et, (et || cf == 4'd0 || cf == 4'd5 || cf == 4'd7) ? "R8" : "R9",
        "cond_taken", {31'h0, cond_taken}, {31'h0, et});
    chk(cond_illegal == ei, "R9", "cond_illegal", {31'h0, cond_illegal}, {31'h0, ei});
    tg = tag_of(v, op);
    if (si == 4'd0 && v) tg = {tg, "/R10"};
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(acc == m_acc, tg, "acc", acc, m_acc);
    chk(status == m_st, {tg, "/R2"}, "status", {16'h0, status}, {16'h0, m_st});
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(acc == 32'h0 && status == 16'h0, "R1", "reset state", acc, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc == 32'h0 && status == 16'h0, "R1", "after release", {status, 16'h0}, 32'h0);

    // directed corners
    step(1, 4'd1, 4'd2, 16'h8000, 0, 0, 0, 0);   // R3 load negative
    step(1, 4'd6, 4'd0, 16'h1234, 0, 0, 0, 0);   // R10 constant all ones via OR
    step(1, 4'd5, 4'd1, 16'h0000, 0, 0, 0, 0);   // R6 AND to zero
    step(1, 4'd4, 4'd0, 16'h0000, 0, 0, 0, 0);   // R10 add 0xFFFF
    step(1, 4'd4, 4'd1, 16'h0001, 0, 0, 0, 0);   // R4 carry out, intermediate not zero
    step(1, 4'd2, 4'd1, 16'h0001, 0, 0, 0, 0);   // R4 0-1
    step(1, 4'd3, 4'd1, 16'hFFFF, 0, 0, 0, 0);   // R5 compare equal -> Z
    step(1, 4'd8, 4'd1, 0, 3'd7, 4'd5, 1, 0);    // R7 abs when Z==1
    step(1, 4'd8, 4'd1, 0, 3'd6, 4'd7, 0, 0);    // R7 negate when N==0
    step(1, 4'd8, 4'd1, 0, 3'd2, 4'd3, 0, 0);    // R9 illegal, no change
    step(1, 4'd8, 4'd1, 0, 3'd4, 4'd0, 0, 0);    // R7 unsupported sub-op
    step(0, 4'd1, 4'd1, 16'hABCD, 0, 4'd9, 0, 1); // R11 idle, R9 via cond_req
    step(1, 4'd12, 4'd1, 16'hABCD, 0, 0, 0, 0);  // R11 unused op code

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op, cf;
      logic [15:0] x;
      op = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) op = 4'($urandom_range(1, 8));
      case ($urandom_range(0, 5))
        0: x = m_acc[31:16];
        1: x = 16'h0000;
        2: x = 16'h8000;
        default: x = 16'($urandom);
      endcase
      case ($urandom_range(0, 4))
        0: cf = 4'd0;
        1: cf = 4'd5;
        2: cf = 4'd7;
        default: cf = 4'($urandom_range(0, 15));
      endcase
      step(($urandom_range(0, 7) != 0), op, 4'($urandom_range(0, 3)), x,
           3'($urandom_range(0, 7)), cf, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule